// File: doc/BRIEF.md
# USB PHY Port Power Sequencer

This block brings up and shuts down four USB 2.0 PHY ports in a fixed order. The four ports are a device port, a host port and two high-speed inter-chip ports, HSIC0 and HSIC1. A requester presents a port index, an on/off flag and the measured reference-clock rate in kHz. The block accepts the request when it is idle. It then walks the port through its sequence and answers with a one-cycle done pulse and an error flag.

The block drives a 3-bit reference-frequency select, a 15-bit power-down field, an 11-bit reset field and three isolation enables. On power-up it writes the frequency code and clears the port's power-down bits. It then pulses the port's reset bits for a fixed time, clears them, and only after that releases isolation. On power-down it isolates the port first and then sets its power-down bits.

HSIC0 cannot run without the device port. Bringing HSIC0 up also runs the full power-up sequence on the device port. Bringing HSIC0 down also takes the device port down, unless the device port was itself requested on.

Top module: `usb_pps_top`

## Requirements
- R1: After reset, the power-down field is 15'h7FF9: every port's bits are set, and bits 1 and 2 are 0. The reset field is 0, all isolation enables are 0, the frequency select is 0, busy is 0 and every port-enabled flag is 0.
- R2: A request whose port index is 4 or more completes with done and error both high. No output other than done/error changes.
- R3: On power-up, the frequency select is taken from the rate in kHz: 9600→0, 10000→1, 12000→2, 19200→3, 20000→4, 24000→5, 50000→7. Any other rate makes a power-up request finish with error set and no output changed.
- R4: Each port's power-down bits are: device {0,3,4,5}, host {6,7,8}, HSIC0 {9,10,11}, HSIC1 {12,13,14}. Power-up clears them and power-down sets them.
- R5: Each port's reset bits are: device {0}, host {3}, HSIC0 {3,6,8}, HSIC1 {6,9}. The reset pulse lasts exactly CLK_KHZ*HOLD_US/1000 clock cycles (1000 at the defaults).
- R6: During power-up, the frequency select already holds the new code when the power-down bits clear. The reset pulse starts after that, and isolation is released strictly after the reset bits clear.
- R7: During power-down, isolation is asserted strictly before the power-down bits are set, and no reset bit is raised.
- R8: Isolation enable bit 0 serves both the device and host ports, bit 1 serves HSIC0 and bit 2 serves HSIC1. A value of 1 means released, so isolating either device or host drives bit 0 to 0.
- R9: Powering up HSIC0 also powers up the device port: its power-down bits clear, its reset bit pulses and isolation bit 0 is released. The device port's enabled flag stays 0.
- R10: Powering down HSIC0 also powers down the device port only when the device port's enabled flag is 0. Otherwise the device port stays powered and released.
- R11: While busy is high, new requests are ignored. Every accepted request produces exactly one done pulse, one cycle long.
- R12: The port-enabled flag (bit = port index) is set by a successful power-up of that port and cleared by its power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is low |
| req_on_i | input | 1 | 1 = power up, 0 = power down |
| req_port_i | input | 3 | Port index |
| req_rate_khz_i | input | 16 | Measured reference-clock rate in kHz |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with done_o |
| fsel_o | output | 3 | Reference-frequency select |
| pwrdn_o | output | 15 | Per-port power-down bits |
| rst_o | output | 11 | Per-port reset bits |
| iso_en_o | output | 3 | Isolation enables, 1 = released |
| port_en_o | output | 4 | Per-port enabled flags |

## Verification
The bench times each sequence step cycle by cycle. A design that released isolation during the reset pulse, pulsed reset on power-down, or set power-down bits while the port was still unisolated would show an out-of-order event index. The reset pulse width is measured exactly, so an off-by-one hold counter would be caught. The HSIC0 dependency is tested both with the device port left off and with it requested on: a design that ignored the device-enabled flag would either leave the device powered or cut it off. Invalid indices, unsupported rates and requests raised while busy must leave every output untouched, which catches a design that half-applies a rejected request.

// File: rtl/usb_pps_pkg.sv
package usb_pps_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PWR_W     = 15;
  localparam int RST_W     = 11;
  localparam int ISO_W     = 3;
  localparam int FSEL_W    = 3;

  typedef enum logic [1:0] {
    P_DEV   = 2'd0,
    P_HOST  = 2'd1,
    P_HSIC0 = 2'd2,
    P_HSIC1 = 2'd3
  } port_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLK, ST_PWR, ST_RST, ST_HOLD, ST_ISO_REL, ST_ISO_SET, ST_PDN, ST_DONE
  } state_e;

  function automatic logic [PWR_W-1:0] pwr_mask(input logic [1:0] p);
    case (p)
      2'd0:    pwr_mask = 15'h0039;
      2'd1:    pwr_mask = 15'h01C0;
      2'd2:    pwr_mask = 15'h0E00;
      default: pwr_mask = 15'h7000;
    endcase
  endfunction

  function automatic logic [RST_W-1:0] rst_mask(input logic [1:0] p);
    case (p)
      2'd0:    rst_mask = 11'h001;
      2'd1:    rst_mask = 11'h008;
      2'd2:    rst_mask = 11'h148;
      default: rst_mask = 11'h240;
    endcase
  endfunction

  function automatic logic [1:0] iso_index(input logic [1:0] p);
    case (p)
      2'd0, 2'd1: iso_index = 2'd0;
      2'd2:       iso_index = 2'd1;
      default:    iso_index = 2'd2;
    endcase
  endfunction

  function automatic logic [PWR_W-1:0] pwr_all();
    logic [PWR_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PORTS; i++) m |= pwr_mask(2'(i));
    return m;
  endfunction
endpackage

// File: rtl/usb_pps_rate_dec.sv
module usb_pps_rate_dec
  import usb_pps_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic [RATE_W-1:0] rate_khz_i,
  output logic [FSEL_W-1:0] code_o,
  output logic              ok_o
);
  always_comb begin
    ok_o   = 1'b1;
    code_o = '0;
    case (32'(rate_khz_i))
      32'd9600:  code_o = 3'd0;
      32'd10000: code_o = 3'd1;
      32'd12000: code_o = 3'd2;
      32'd19200: code_o = 3'd3;
      32'd20000: code_o = 3'd4;
      32'd24000: code_o = 3'd5;
      32'd50000: code_o = 3'd7;
      default:   ok_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/usb_pps_port_map.sv
module usb_pps_port_map
  import usb_pps_pkg::*;
(
  input  logic [1:0]       port_i,
  output logic [PWR_W-1:0] pwr_m_o,
  output logic [RST_W-1:0] rst_m_o,
  output logic [1:0]       iso_idx_o
);
  assign pwr_m_o   = pwr_mask(port_i);
  assign rst_m_o   = rst_mask(port_i);
  assign iso_idx_o = iso_index(port_i);
endmodule

// File: rtl/usb_pps_hold_timer.sv
module usb_pps_hold_timer #(
  parameter int HOLD_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expired_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(HOLD_CYC - 1);
      run_q <= 1'b1;
    end else if (expired_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_TMR_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q); // R5
endmodule

// File: rtl/usb_pps_top.sv
module usb_pps_top
  import usb_pps_pkg::*;
#(
  parameter int CLK_KHZ = 100000,
  parameter int HOLD_US = 10,
  parameter int RATE_W  = 16,
  parameter int PORT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_on_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [RATE_W-1:0] req_rate_khz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [FSEL_W-1:0] fsel_o,
  output logic [PWR_W-1:0]  pwrdn_o,
  output logic [RST_W-1:0]  rst_o,
  output logic [ISO_W-1:0]  iso_en_o,
  output logic [NUM_PORTS-1:0] port_en_o
);
  localparam int HOLD_RAW = CLK_KHZ * HOLD_US / 1000;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam logic [PWR_W-1:0] PWR_RST = pwr_all();

  state_e               state_q;
  logic [1:0]           cur_q;
  logic                 dep_q;
  logic                 err_q;
  logic [FSEL_W-1:0]    code_q;
  logic [FSEL_W-1:0]    fsel_q;
  logic [PWR_W-1:0]     pwrdn_q;
  logic [RST_W-1:0]     rst_q;
  logic [ISO_W-1:0]     iso_q;
  logic [NUM_PORTS-1:0] en_q;

  logic [FSEL_W-1:0] rate_code;
  logic              rate_ok;
  logic [PWR_W-1:0]  pm;
  logic [RST_W-1:0]  rm;
  logic [1:0]        ii;
  logic              tmr_start, tmr_exp;
  logic              port_bad;

  usb_pps_rate_dec #(.RATE_W(RATE_W)) u_rate (
    .rate_khz_i(req_rate_khz_i), .code_o(rate_code), .ok_o(rate_ok));

  usb_pps_port_map u_map (
    .port_i(cur_q), .pwr_m_o(pm), .rst_m_o(rm), .iso_idx_o(ii));

  usb_pps_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_start), .expired_o(tmr_exp));

  assign port_bad  = 32'(req_port_i) >= NUM_PORTS;
  assign tmr_start = (state_q == ST_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      dep_q   <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= '0;
      fsel_q  <= '0;
      pwrdn_q <= PWR_RST;
      rst_q   <= '0;
      iso_q   <= '0;
      en_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (port_bad || (req_on_i && !rate_ok)) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            err_q   <= 1'b0;
            cur_q   <= req_port_i[1:0];
            dep_q   <= 1'b0;
            code_q  <= rate_code;
            state_q <= req_on_i ? ST_CLK : ST_ISO_SET;
          end
        end
        ST_CLK: begin
          fsel_q  <= code_q;
          state_q <= ST_PWR;
        end
        ST_PWR: begin
          pwrdn_q <= pwrdn_q & ~pm;
          state_q <= ST_RST;
        end
        ST_RST: begin
          rst_q   <= rst_q | rm;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (tmr_exp) begin
          rst_q   <= rst_q & ~rm;
          state_q <= ST_ISO_REL;
        end
        ST_ISO_REL: begin
          iso_q[ii] <= 1'b1;
          if (!dep_q) en_q[cur_q] <= 1'b1;
          // HSIC0 needs the device port running
          if (!dep_q && cur_q == P_HSIC0) begin
            cur_q   <= P_DEV;
            dep_q   <= 1'b1;
            state_q <= ST_CLK;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_ISO_SET: begin
          iso_q[ii] <= 1'b0;
          if (!dep_q) en_q[cur_q] <= 1'b0;
          state_q <= ST_PDN;
        end
        ST_PDN: begin
          pwrdn_q <= pwrdn_q | pm;
          if (!dep_q && cur_q == P_HSIC0 && !en_q[P_DEV]) begin
            cur_q   <= P_DEV;
            dep_q   <= 1'b1;
            state_q <= ST_ISO_SET;
          end else begin
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = done_o & err_q;
  assign fsel_o    = fsel_q;
  assign pwrdn_o   = pwrdn_q;
  assign rst_o     = rst_q;
  assign iso_en_o  = iso_q;
  assign port_en_o = en_q;

  AST_ISO0_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_en_o[0] |-> ((pwrdn_o & pwr_mask(2'd0)) == '0) || ((pwrdn_o & pwr_mask(2'd1)) == '0)); // R6
  AST_ISO1_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_en_o[1] |-> (pwrdn_o & pwr_mask(2'd2)) == '0); // R7
  AST_ISO2_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_en_o[2] |-> (pwrdn_o & pwr_mask(2'd3)) == '0); // R8
  AST_RST_IN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o != '0) |-> busy_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_FSEL_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> $stable(fsel_o)); // R3
  AST_PWR_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(pwrdn_o)); // R11
  AST_EN_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(port_en_o)); // R12
endmodule

// File: tb/usb_pps_top_bench.sv
module usb_pps_top_bench;
  localparam int HOLD = 1000;
  localparam logic [14:0] PM_DEV = 15'h0039, PM_HOST = 15'h01C0,
                          PM_H0  = 15'h0E00, PM_H1   = 15'h7000;
  localparam logic [10:0] RM_DEV = 11'h001, RM_HOST = 11'h008,
                          RM_H0  = 11'h148, RM_H1   = 11'h240;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_on = 0;
  logic [2:0] req_port = 0;
  logic [15:0] req_rate = 0;
  logic busy, done, err;
  logic [2:0] fsel;
  logic [14:0] pwrdn;
  logic [10:0] rsto;
  logic [2:0] iso;
  logic [3:0] pen;

  int checks = 0, fails = 0, cyc = 0;
  int t_pc, t_rh, t_rl, t_ih, t_il, t_ps, t_ps_dev;
  bit rst_seen, dev_rst_seen;
  logic [2:0] fsel_at_pc;
  bit last_err;

  always #5 clk = ~clk;

  usb_pps_top u_usb_pps_top (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_on_i(req_on),
    .req_port_i(req_port), .req_rate_khz_i(req_rate), .busy_o(busy), .done_o(done),
    .err_o(err), .fsel_o(fsel), .pwrdn_o(pwrdn), .rst_o(rsto), .iso_en_o(iso),
    .port_en_o(pen));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cyc=%0d expected <150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit on, input logic [2:0] port, input logic [15:0] rate,
                       input logic [14:0] pm, input logic [10:0] rm, input int ii);
    int s;
    t_pc = 0; t_rh = 0; t_rl = 0; t_ih = 0; t_il = 0; t_ps = 0; t_ps_dev = 0;
    rst_seen = 0; dev_rst_seen = 0;
    @(negedge clk);
    req_valid = 1; req_on = on; req_port = port; req_rate = rate;
    @(negedge clk);
    req_valid = 0;
    s = 1;
    forever begin
      if (t_pc == 0 && (pwrdn & pm) == 0) begin t_pc = s; fsel_at_pc = fsel; end
      if (t_rh == 0 && (rsto & rm) == rm) t_rh = s;
      if (t_rh != 0 && t_rl == 0 && (rsto & rm) == 0) t_rl = s;
      if (t_ih == 0 && iso[ii]) t_ih = s;
      if (t_il == 0 && !iso[ii]) t_il = s;
      if (t_ps == 0 && (pwrdn & pm) == pm) t_ps = s;
      if (rsto != 0) rst_seen = 1;
      if (rsto[0]) dev_rst_seen = 1;
      if (done) begin last_err = err; break; end
      @(negedge clk);
      s++;
      if (s > 5000) break;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(pwrdn == 15'h7FF9, "R1", "pwrdn", pwrdn, 15'h7FF9);
    chk(rsto == 0 && iso == 0 && fsel == 0 && pen == 0 && !busy, "R1", "rst/iso/fsel/en/busy",
        {rsto, iso, fsel, pen, busy}, 0);
  endtask

  task automatic t_dev_cycle;
    issue(1, 0, 16'd24000, PM_DEV, RM_DEV, 0);
    chk(!last_err, "R6", "err on dev up", last_err, 0);
    chk(fsel == 5 && fsel_at_pc == 5, "R3", "fsel 24MHz", fsel_at_pc, 5);
    chk((pwrdn & PM_DEV) == 0 && (pwrdn & ~PM_DEV) == (15'h7FF9 & ~PM_DEV), "R4", "dev pwr bits",
        pwrdn, 15'h7FF9 & ~PM_DEV);
    chk(t_rl - t_rh == HOLD, "R5", "reset width", t_rl - t_rh, HOLD);
    chk(t_pc != 0 && t_pc < t_rh && t_rl < t_ih, "R6", "up order",
        {t_pc[7:0], t_rh[7:0], t_ih[15:0]}, 0);
    chk(iso == 3'b001 && pen == 4'b0001, "R12", "dev enabled", {iso, pen}, {3'b001, 4'b0001});
    issue(0, 0, 16'd0, PM_DEV, RM_DEV, 0);
    chk(t_il != 0 && t_il < t_ps, "R7", "down order", {t_il[15:0], t_ps[15:0]}, 0);
    chk(!rst_seen, "R7", "no reset on down", rst_seen, 0);
    chk(pwrdn == 15'h7FF9 && iso == 0 && pen == 0, "R12", "dev off state", {pwrdn, iso, pen}, {15'h7FF9, 7'h0});
  endtask

  task automatic t_rates;
    logic [15:0] rates [7] = '{16'd9600, 16'd10000, 16'd12000, 16'd19200, 16'd20000, 16'd24000, 16'd50000};
    logic [2:0]  codes [7] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
    for (int k = 0; k < 7; k++) begin
      issue(1, 1, rates[k], PM_HOST, RM_HOST, 0);
      chk(fsel == codes[k] && !last_err, "R3", "rate code", fsel, codes[k]);
      if (k == 0) chk(t_rl - t_rh == HOLD && (pwrdn & PM_HOST) == 0, "R5", "host reset/pwr",
                      t_rl - t_rh, HOLD);
      issue(0, 1, 16'd0, PM_HOST, RM_HOST, 0);
    end
  endtask

  task automatic t_bad;
    logic [31:0] snap;
    snap = {pwrdn, rsto, iso, fsel};
    issue(1, 3'd5, 16'd24000, PM_DEV, RM_DEV, 0);
    chk(last_err, "R2", "bad port err", last_err, 1);
    chk({pwrdn, rsto, iso, fsel} == snap && pen == 0, "R2", "bad port no change",
        {pwrdn, rsto, iso, fsel}, snap);
    issue(1, 3'd1, 16'd25000, PM_HOST, RM_HOST, 0);
    chk(last_err, "R3", "bad rate err", last_err, 1);
    chk({pwrdn, rsto, iso, fsel} == snap && pen == 0, "R3", "bad rate no change",
        {pwrdn, rsto, iso, fsel}, snap);
  endtask

  task automatic t_hsic1;
    issue(1, 3, 16'd12000, PM_H1, RM_H1, 2);
    chk((pwrdn & PM_H1) == 0 && iso == 3'b100 && pen == 4'b1000, "R8", "hsic1 up",
        {pwrdn, iso, pen}, {15'h7FF9 & ~PM_H1, 3'b100, 4'b1000});
    chk(t_rl - t_rh == HOLD && t_rl < t_ih, "R5", "hsic1 reset", t_rl - t_rh, HOLD);
    issue(0, 3, 16'd0, PM_H1, RM_H1, 2);
    chk(pwrdn == 15'h7FF9 && iso == 0 && pen == 0, "R12", "hsic1 down", {pwrdn, iso, pen}, {15'h7FF9, 7'h0});
  endtask

  task automatic t_hsic0_dep;
    issue(1, 2, 16'd19200, PM_H0, RM_H0, 1);
    chk(t_rl - t_rh == HOLD && dev_rst_seen, "R5", "hsic0+dev reset", {t_rl - t_rh}, HOLD);
    chk((pwrdn & (PM_DEV | PM_H0)) == 0 && iso == 3'b011, "R9", "dev up with hsic0",
        {pwrdn, iso}, {15'h7FF9 & ~(PM_DEV | PM_H0), 3'b011});
    chk(pen == 4'b0100, "R9", "dev flag stays 0", pen, 4'b0100);
    issue(0, 2, 16'd0, PM_H0, RM_H0, 1);
    chk(pwrdn == 15'h7FF9 && iso == 0 && pen == 0, "R10", "dev down with hsic0",
        {pwrdn, iso, pen}, {15'h7FF9, 7'h0});
  endtask

  task automatic t_hsic0_keep;
    issue(1, 0, 16'd20000, PM_DEV, RM_DEV, 0);
    issue(1, 2, 16'd20000, PM_H0, RM_H0, 1);
    issue(0, 2, 16'd0, PM_H0, RM_H0, 1);
    chk((pwrdn & PM_DEV) == 0 && (pwrdn & PM_H0) == PM_H0, "R10", "dev kept",
        pwrdn, 15'h7FF9 & ~PM_DEV);
    chk(iso == 3'b001 && pen == 4'b0001, "R10", "dev iso/flag kept", {iso, pen}, {3'b001, 4'b0001});
    issue(0, 0, 16'd0, PM_DEV, RM_DEV, 0);
  endtask

  task automatic t_shared;
    issue(1, 0, 16'd9600, PM_DEV, RM_DEV, 0);
    issue(1, 1, 16'd9600, PM_HOST, RM_HOST, 0);
    chk(iso == 3'b001 && pen == 4'b0011, "R8", "both up", {iso, pen}, {3'b001, 4'b0011});
    issue(0, 1, 16'd0, PM_HOST, RM_HOST, 0);
    chk(iso == 3'b000 && (pwrdn & PM_DEV) == 0, "R8", "shared iso dropped", iso, 0);
    issue(0, 0, 16'd0, PM_DEV, RM_DEV, 0);
  endtask

  task automatic t_busy;
    int dn;
    dn = 0;
    @(negedge clk);
    req_valid = 1; req_on = 1; req_port = 3; req_rate = 16'd10000;
    @(negedge clk);
    req_valid = 0;
    repeat (5) @(negedge clk);
    chk(busy, "R11", "busy during seq", busy, 1);
    req_valid = 1; req_on = 1; req_port = 1; req_rate = 16'd10000;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 2500; k++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk(dn == 1, "R11", "one done pulse", dn, 1);
    chk((pwrdn & PM_HOST) == PM_HOST && pen == 4'b1000, "R11", "busy req ignored",
        {pwrdn, pen}, {15'h7FF9 & ~PM_H1, 4'b1000});
    issue(0, 3, 16'd0, PM_H1, RM_H1, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_dev_cycle;
    t_rates;
    t_bad;
    t_hsic1;
    t_hsic0_dep;
    t_hsic0_keep;
    t_shared;
    t_busy;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule